// File: doc/BRIEF.md
# Latched Bit and Error Counters for BER Measurement

This block keeps two live counters for bit-error-rate measurement on a receive stream. One counts received bit clocks. The other counts bits flagged as errored. Both run in the receive clock domain. The error counter is frozen while the pattern detector reports loss of synchronization. The bit counter keeps running whatever the sync state.

A host raises a latch request to take a measurement. The request is synchronized, and its rising edge copies both live counts into holding registers in a single clock. The same edge restarts the live counters. The host then reads a held count one byte at a time through a window of byte addresses, and a select input picks which of the two counts the window shows. Each counter has an overflow flag. The flag is set when the counter wraps and stays set until the host clears it.

Top module: `bc_ber_counters`

## Requirements
- R1: The bit counter advances by one on every clock edge at which `rx_en` is high, whatever the value of `los`.
- R2: The error counter advances by one on a clock edge only when `rx_en` and `err_flag` are high and `los` is low. While `los` is high, errors are not counted.
- R3: Each counter is `CNT_W` bits wide (48 by default). From all-ones it wraps to zero.
- R4: A wrap sets the sticky flag for that counter: `bit_ovf` for the bit counter, `err_ovf` for the error counter. A flag stays set until `ovf_clr` is high for one cycle (bit 0 clears `bit_ovf`, bit 1 clears `err_ovf`). If a wrap and a clear fall in the same cycle, the flag ends up set.
- R5: `latch_req` passes through a two-flop synchronizer. Its rising edge is acted on at the third clock edge after the input rises. At that edge both live counts are copied into their holding registers and the live counters are cleared.
- R6: An increment on the same clock edge as the snapshot is not part of the snapshot. The new live count starts at one.
- R7: Addresses 0xA through 0xF return the held count one byte at a time: 0xA gives bits 7:0, 0xB gives bits 15:8, and so on up to 0xF, which gives bits 47:40. With `rd_sel`=0 the window shows the bit count; with `rd_sel`=1 it shows the error count. `rd_data` is registered and shows the addressed byte one clock after the address is applied.
- R8: Any address outside the window returns 0x00.
- R9: After reset the live counts, held counts and overflow flags are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive clock enable: a bit is present on this cycle |
| err_flag | input | 1 | The bit on this cycle was received in error |
| los | input | 1 | Loss of pattern synchronization |
| latch_req | input | 1 | Latch-count control; a rising edge snapshots and clears the counters |
| ovf_clr | input | 2 | Write-one-to-clear for the flags: bit 0 for `bit_ovf`, bit 1 for `err_ovf` |
| rd_addr | input | ADDR_W | Host byte read address |
| rd_sel | input | 1 | 0 reads the bit count, 1 reads the error count |
| rd_data | output | 8 | Registered read byte |
| bit_ovf | output | 1 | Sticky overflow flag of the bit counter |
| err_ovf | output | 1 | Sticky overflow flag of the error counter |

## Verification
The bench exercises the counters with several stimulus patterns, and each one separates different behaviour:
- A run of 300 enabled bits containing 5 errors yields values with nonzero data in two bytes. This exposes byte ordering mistakes and swaps between the two counts.
- A burst taken with `los` high and then low shows whether errors are gated by sync while bits keep counting.
- Raising the enable and the latch request together places increments on both sides of the snapshot edge. This shows which interval the same-edge increment lands in.
- A reduced-width instance runs through a full wrap. It shows that the count returns to zero, that the flags stick, and that each flag clears independently.

// File: rtl/bc_pkg.sv
package bc_pkg;
  typedef enum logic {CNT_BITS = 1'b0, CNT_ERRS = 1'b1} cnt_kind_e;
  localparam int NUM_CNT = 2;

  function automatic int bytes_for(input int width);
    return (width + 7) / 8;
  endfunction
endpackage

// File: rtl/bc_latch_edge.sv
module bc_latch_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_async,
  output logic snap
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], req_async};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign snap = sync_q[SYNC_STAGES-1] & ~prev_q;

  // R5: the snapshot strobe lasts one cycle per rising edge
  assert_snap_single_R5: assert property (@(posedge clk) disable iff (rst)
    snap |=> !snap);
endmodule

// File: rtl/bc_live_counter.sv
module bc_live_counter #(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             snap,
  input  logic             clr_ovf,
  output logic [CNT_W-1:0] held,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] live;
  logic             wrap;

  assign wrap = cnt_en & ~snap & (live == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      live <= '0;
      held <= '0;
    end else if (snap) begin
      held <= live;
      live <= cnt_en ? ONE : '0;
    end else if (cnt_en) begin
      live <= live + ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          ovf <= 1'b0;
    else if (wrap)    ovf <= 1'b1;
    else if (clr_ovf) ovf <= 1'b0;
  end

  assert_snap_copies_R5: assert property (@(posedge clk) disable iff (rst)
    snap |=> held == $past(live));

  assert_same_edge_R6: assert property (@(posedge clk) disable iff (rst)
    (snap && cnt_en) |=> live == ONE);

  assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !snap && live == '1) |=> (live == '0 && ovf));

  assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (ovf && !clr_ovf) |=> ovf);
endmodule

// File: rtl/bc_read_mux.sv
module bc_read_mux #(
  parameter int CNT_W     = 48,
  parameter int ADDR_W    = 4,
  parameter int BASE_ADDR = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_sel,
  input  logic [CNT_W-1:0]  held_bits,
  input  logic [CNT_W-1:0]  held_errs,
  output logic [7:0]        rd_data
);
  localparam int NBYTES = bc_pkg::bytes_for(CNT_W);
  localparam int PAD_W  = NBYTES * 8;

  logic [PAD_W-1:0] pad_sel;
  logic             in_win;
  int               idx;

  always_comb begin
    pad_sel = '0;
    pad_sel[CNT_W-1:0] = rd_sel ? held_errs : held_bits;
    idx    = int'(rd_addr) - BASE_ADDR;
    in_win = (idx >= 0) && (idx < NBYTES);
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= 8'h00;
    else if (in_win) rd_data <= pad_sel[idx*8 +: 8];
    else             rd_data <= 8'h00;
  end

  assert_outside_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (int'(rd_addr) < BASE_ADDR || int'(rd_addr) >= BASE_ADDR + NBYTES)
      |=> rd_data == 8'h00);
endmodule

// File: rtl/bc_ber_counters.sv
module bc_ber_counters #(
  parameter int CNT_W     = 48,
  parameter int ADDR_W    = 4,
  parameter int BASE_ADDR = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              err_flag,
  input  logic              los,
  input  logic              latch_req,
  input  logic [1:0]        ovf_clr,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_sel,
  output logic [7:0]        rd_data,
  output logic              bit_ovf,
  output logic              err_ovf
);
  import bc_pkg::*;

  logic                 snap;
  logic [NUM_CNT-1:0]   cnt_en;
  logic [NUM_CNT-1:0]   ovf_vec;
  logic [CNT_W-1:0]     held [NUM_CNT];

  bc_latch_edge #(.SYNC_STAGES(2)) u_edge (
    .clk(clk), .rst(rst), .req_async(latch_req), .snap(snap)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    if (cnt_kind_e'(g) == CNT_BITS) begin : g_bits
      assign cnt_en[g] = rx_en;
    end else begin : g_errs
      assign cnt_en[g] = rx_en & err_flag & ~los;
    end

    bc_live_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .cnt_en(cnt_en[g]), .snap(snap),
      .clr_ovf(ovf_clr[g]), .held(held[g]), .ovf(ovf_vec[g])
    );
  end

  bc_read_mux #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_rd (
    .clk(clk), .rst(rst), .rd_addr(rd_addr), .rd_sel(rd_sel),
    .held_bits(held[CNT_BITS]), .held_errs(held[CNT_ERRS]), .rd_data(rd_data)
  );

  assign bit_ovf = ovf_vec[CNT_BITS];
  assign err_ovf = ovf_vec[CNT_ERRS];
endmodule

// File: tb/tb_bc_ber_counters.sv
module tb_bc_ber_counters;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic rx_en = 0, err_flag = 0, los = 0, latch_req = 0;
  logic [1:0] ovf_clr = 2'b00;
  logic [3:0] rd_addr = 4'h0;
  logic rd_sel = 0;
  logic [7:0] rd_data;
  logic bit_ovf, err_ovf;

  logic w_en = 0, w_err = 0;
  logic [1:0] w_clr = 2'b00;
  logic [3:0] w_addr = 4'h0;
  logic [7:0] w_data;
  logic w_bovf, w_eovf;

  bc_ber_counters dut (
    .clk(clk), .rst(rst), .rx_en(rx_en), .err_flag(err_flag), .los(los),
    .latch_req(latch_req), .ovf_clr(ovf_clr), .rd_addr(rd_addr),
    .rd_sel(rd_sel), .rd_data(rd_data), .bit_ovf(bit_ovf), .err_ovf(err_ovf)
  );

  bc_ber_counters #(.CNT_W(16)) dut_w (
    .clk(clk), .rst(rst), .rx_en(w_en), .err_flag(w_err), .los(1'b0),
    .latch_req(1'b0), .ovf_clr(w_clr), .rd_addr(w_addr),
    .rd_sel(1'b0), .rd_data(w_data), .bit_ovf(w_bovf), .err_ovf(w_eovf)
  );

  int tests_run = 0;
  int tests_failed = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic rd_req = 0;
  logic req_q = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(posedge clk) req_q <= rd_req;
  always @(negedge clk) begin
    if (req_q) begin
      if (exp_q.size() == 0) check("R7 scoreboard underflow", 64'd1, 64'd0);
      else check(tag_q.pop_front(), {56'd0, rd_data}, {56'd0, exp_q.pop_front()});
    end
  end

  // driver: queue a read and its expected byte
  task automatic read_byte(input logic [3:0] a, input logic s, input logic [7:0] e, input string tag);
    @(negedge clk);
    rd_addr = a; rd_sel = s; rd_req = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  task automatic drain();
    @(negedge clk); rd_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_window(input logic s, input logic [47:0] v, input string tag);
    for (int b = 0; b < 6; b++) read_byte(4'hA + 4'(b), s, v[b*8 +: 8], tag);
    drain();
  endtask

  task automatic latch_pulse();
    @(negedge clk); latch_req = 1'b1;
    repeat (6) @(negedge clk);
    latch_req = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    read_window(1'b0, 48'd0, "R9 reset bit count");
    read_window(1'b1, 48'd0, "R9 reset error count");
    check("R9 reset bit_ovf", {63'd0, bit_ovf}, 64'd0);
    check("R9 reset err_ovf", {63'd0, err_ovf}, 64'd0);

    // R1 R2 R7: 300 bits, 5 errors
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); rx_en = 1'b1; err_flag = (i < 5);
    end
    @(negedge clk); rx_en = 1'b0; err_flag = 1'b0;
    latch_pulse();
    read_window(1'b0, 48'd300, "R7 bit count byte order");
    read_window(1'b1, 48'd5, "R7 error count select");

    // R2: los gates errors, R1: bits still count
    @(negedge clk); los = 1'b1; rx_en = 1'b1; err_flag = 1'b1;
    repeat (10) @(negedge clk);
    los = 1'b0;
    repeat (4) @(negedge clk);
    rx_en = 1'b0; err_flag = 1'b0;
    latch_pulse();
    read_window(1'b0, 48'd14, "R1 bits counted during los");
    read_window(1'b1, 48'd4, "R2 errors held during los");

    // R5 R6: increment on the snapshot edge goes to the new interval
    @(negedge clk); rx_en = 1'b1; err_flag = 1'b1; latch_req = 1'b1;
    repeat (3) @(negedge clk);
    rx_en = 1'b0; err_flag = 1'b0;
    read_window(1'b0, 48'd2, "R5 snapshot at third edge");
    read_window(1'b1, 48'd2, "R5 error snapshot");
    latch_req = 1'b0;
    repeat (4) @(negedge clk);
    latch_pulse();
    read_window(1'b0, 48'd1, "R6 same-edge bit in new interval");
    read_window(1'b1, 48'd1, "R6 same-edge error in new interval");

    // R8: outside the window
    read_byte(4'h9, 1'b0, 8'h00, "R8 address 0x9");
    read_byte(4'h0, 1'b1, 8'h00, "R8 address 0x0");
    read_byte(4'hA, 1'b0, 8'h01, "R8 window still live");
    drain();
    check("R4 no spurious bit_ovf", {63'd0, bit_ovf}, 64'd0);

    // R3 R4: wrap on the 16-bit instance
    @(negedge clk); w_en = 1'b1; w_err = 1'b1;
    repeat (65535) @(negedge clk);
    check("R3 no flag before wrap", {62'd0, w_bovf, w_eovf}, 64'd0);
    @(negedge clk); w_en = 1'b0; w_err = 1'b0;
    check("R3 wrap sets both flags", {62'd0, w_bovf, w_eovf}, 64'd3);
    repeat (5) @(negedge clk);
    check("R4 flags sticky", {62'd0, w_bovf, w_eovf}, 64'd3);
    w_clr = 2'b01;
    @(negedge clk); w_clr = 2'b00;
    check("R4 clear bit flag only", {62'd0, w_bovf, w_eovf}, 64'd1);
    w_clr = 2'b10;
    @(negedge clk); w_clr = 2'b00;
    check("R4 clear error flag", {62'd0, w_bovf, w_eovf}, 64'd0);
    w_addr = 4'hC;
    @(negedge clk);
    check("R8 beyond narrow window", {56'd0, w_data}, 64'd0);

    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests_run++; tests_failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule